// File: doc/BRIEF.md
# Command-Queue Instruction Executor

The executor walks a list of 64-bit instructions held in a command buffer, fetching one word at a time through a read port that answers one cycle after each request. Each word carries an opcode, a subsystem code, a 16-bit offset or event number, and a 32-bit value. The executor carries out register writes and polls on a request/acknowledge register bus, waits on and updates a local array of event flags, raises an interrupt pulse, and follows jumps. A sequence finishes with a jump whose value equals the pass marker. The executor then goes idle and raises a sticky done flag.

Masking is set up by a separate instruction. A mask instruction latches a word that holds the inverse of the caller's mask. A later write or poll uses that word only if bit 0 of its own offset is set. A masked write becomes a read followed by a write on the register bus. Event flags are set by pulses on an input vector and are consumed or rewritten by wait-for-event instructions.

Top module: `cmdq_exec`

## Requirements
- R1: Instruction word layout: opcode in bits [63:56], subsystem in [55:48], offset or event number in [47:32], value in [31:0]. The subsystem code appears on `reg_subsys`, and the offset appears on `reg_offset` with bit 0 forced to 0.
- R2: An opcode 0x04 (write) with offset bit 0 clear writes the full 32-bit value and ignores any latched mask.
- R3: Opcode 0x02 (mask) latches its value K. A following write with offset bit 0 set reads the register and then writes back (old & K) | (value & ~K).
- R4: Opcode 0x08 (poll) rereads the register until (data ^ value) & ~K is zero, where K is the latched mask if offset bit 0 is set and zero otherwise. No later instruction is fetched while the poll waits.
- R5: Opcode 0x20 (wait-for-event) takes four value fields: bit 15 enables waiting, bit 0 is the awaited flag value, bit 31 enables an update, and bit 16 is the value written. With 0x80008001 the instruction blocks until the flag is 1 and then clears it.
- R6: A wait-for-event with value 0x80000000 clears the flag without waiting.
- R7: A pulse on `evt_in[n]` sets flag n. When the pulse falls on the same edge where a wait-for-event writes that flag, the pulse wins. Timing: an instruction is decoded two edges after its fetch request is seen, and a wait whose condition already holds completes on the edge after that.
- R8: Opcode 0x40 (end of command) with value bit 0 set makes `irq` high for exactly one cycle. With bit 0 clear, no pulse is produced.
- R9: Opcode 0x10 (jump) with a value equal to JUMP_PASS (default 8) sets `done` and returns to idle. `done` stays set until `done_clr`.
- R10: A jump with any other value adds the value, read as a signed byte offset divided by 8, to the instruction index. Both forward and backward jumps are supported.
- R11: An unknown opcode, or a wait-for-event whose event number is not below EVT_N, sets `err` and stops execution. A new start clears `err`.
- R12: A `start` pulse while the executor is busy is ignored.
- R13: After reset, `busy`, `done`, `err`, `irq`, `ibuf_rd` and `reg_req` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at base_addr when idle |
| base_addr | input | AW | First instruction index |
| done_clr | input | 1 | Clears the done flag |
| ibuf_addr | output | AW | Instruction index being fetched |
| ibuf_rd | output | 1 | Fetch request |
| ibuf_data | input | 64 | Instruction word, one cycle after request |
| ibuf_valid | input | 1 | Qualifies ibuf_data |
| reg_req | output | 1 | Register bus request, held until ack |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_subsys | output | 8 | Subsystem code |
| reg_offset | output | 16 | Register offset, bit 0 zero |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid with ack |
| reg_ack | input | 1 | Completes the request |
| evt_in | input | EVT_N | Event set pulses |
| irq | output | 1 | End-of-command interrupt pulse |
| done | output | 1 | Sticky sequence-complete flag |
| err | output | 1 | Sticky fault flag |
| busy | output | 1 | Executor not idle |

## Verification
An incoming event pulse and a wait-for-event write-back can hit the same flag on the same edge. The bench first sets the flag, then starts a program of two back-to-back waits on it. It watches `ibuf_rd` and counts the stated fetch-to-completion latency so that the next pulse lands exactly on the consuming edge. If the pulse is kept, the second wait finds the flag still set and `done` arrives. If the clear wins, the second wait blocks. A companion run with a single early pulse shows that the second wait does block when no pulse coincides.

// File: rtl/cmdq_exec.sv
module cmdq_exec #(
  parameter int AW = 16,
  parameter int EVT_N = 32,
  parameter logic [31:0] JUMP_PASS = 32'd8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic          done_clr,
  output logic [AW-1:0] ibuf_addr,
  output logic          ibuf_rd,
  input  logic [63:0]   ibuf_data,
  input  logic          ibuf_valid,
  output logic          reg_req,
  output logic          reg_we,
  output logic [7:0]    reg_subsys,
  output logic [15:0]   reg_offset,
  output logic [31:0]   reg_wdata,
  input  logic [31:0]   reg_rdata,
  input  logic          reg_ack,
  input  logic [EVT_N-1:0] evt_in,
  output logic          irq,
  output logic          done,
  output logic          err,
  output logic          busy
);
  localparam int EVT_W = (EVT_N > 1) ? $clog2(EVT_N) : 1;
  localparam logic [7:0] OP_MASK = 8'h02, OP_WRITE = 8'h04, OP_POLL = 8'h08,
                         OP_JUMP = 8'h10, OP_WFE = 8'h20, OP_EOC = 8'h40;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_EXEC, S_RD, S_WR, S_WAIT} st_t;

  st_t               state;
  logic [AW-1:0]     pc;
  logic [63:0]       ins;
  logic [31:0]       mask_q, wdata_q;
  logic [EVT_N-1:0]  flags, flags_n;

  logic [7:0]  op;
  logic [15:0] off;
  logic [31:0] val, keep, jd;
  logic [EVT_W-1:0] evi;
  logic ev_ok, wait_ok, poll_hit;

  assign op   = ins[63:56];
  assign off  = ins[47:32];
  assign val  = ins[31:0];
  assign keep = off[0] ? mask_q : 32'h0;
  assign jd   = $signed(val) >>> 3;
  assign evi  = off[EVT_W-1:0];
  assign ev_ok   = 32'(off) < EVT_N;
  assign wait_ok = !val[15] || (flags[evi] == val[0]);
  assign poll_hit = ((reg_rdata ^ val) & ~keep) == 32'h0;

  assign ibuf_addr  = pc;
  assign ibuf_rd    = state == S_FETCH;
  assign reg_req    = (state == S_RD) || (state == S_WR);
  assign reg_we     = state == S_WR;
  assign reg_subsys = ins[55:48];
  assign reg_offset = {off[15:1], 1'b0};
  assign reg_wdata  = wdata_q;
  assign busy       = state != S_IDLE;

  always_comb begin
    flags_n = flags;
    if (state == S_WAIT && wait_ok && val[31])
      flags_n[evi] = val[16];
    flags_n = flags_n | evt_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pc <= '0;
      ins <= '0;
      mask_q <= '0;
      wdata_q <= '0;
      flags <= '0;
      irq <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
    end else begin
      irq <= 1'b0;
      flags <= flags_n;
      if (done_clr) done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          pc <= base_addr;
          err <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: state <= S_FWAIT;
        S_FWAIT: if (ibuf_valid) begin
          ins <= ibuf_data;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_MASK: begin
              mask_q <= val;
              pc <= pc + 1'b1;
              state <= S_FETCH;
            end
            OP_WRITE: begin
              wdata_q <= val;
              state <= off[0] ? S_RD : S_WR;
            end
            OP_POLL: state <= S_RD;
            OP_WFE: begin
              if (ev_ok) state <= S_WAIT;
              else begin
                err <= 1'b1;
                state <= S_IDLE;
              end
            end
            OP_EOC: begin
              irq <= val[0];
              pc <= pc + 1'b1;
              state <= S_FETCH;
            end
            OP_JUMP: begin
              if (val == JUMP_PASS) begin
                done <= 1'b1;
                state <= S_IDLE;
              end else begin
                pc <= pc + jd[AW-1:0];
                state <= S_FETCH;
              end
            end
            default: begin
              err <= 1'b1;
              state <= S_IDLE;
            end
          endcase
        end
        S_RD: if (reg_ack) begin
          if (op == OP_POLL) begin
            if (poll_hit) begin
              pc <= pc + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            wdata_q <= (reg_rdata & keep) | (val & ~keep);
            state <= S_WR;
          end
        end
        S_WR: if (reg_ack) begin
          pc <= pc + 1'b1;
          state <= S_FETCH;
        end
        S_WAIT: if (wait_ok) begin
          pc <= pc + 1'b1;
          state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (done && !done_clr) |=> done); // R9
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> !busy); // R11
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_offset) && $stable(reg_we))); // R1
  AST_POLL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> !ibuf_rd); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_req && !ibuf_rd)); // R13
endmodule

// File: tb/sim_cmdq_exec.sv
`timescale 1ns/1ps
module sim_cmdq_exec;
  localparam int AW = 16, EVT_N = 32;
  logic clk = 0, rst_n = 0, start = 0, done_clr = 0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] ibuf_addr;
  logic ibuf_rd, ibuf_valid, reg_req, reg_we, reg_ack, irq, done, err, busy;
  logic [63:0] ibuf_data;
  logic [7:0] reg_subsys, last_sub;
  logic [15:0] reg_offset;
  logic [31:0] reg_wdata, reg_rdata;
  logic [EVT_N-1:0] evt_in = '0;

  logic [63:0] imem [64];
  logic [31:0] regs [16];
  logic poke_en = 0;
  logic [3:0] poke_idx = '0;
  logic [31:0] poke_val = '0;
  int checks = 0, fails = 0, irq_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmdq_exec #(.AW(AW), .EVT_N(EVT_N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .done_clr(done_clr),
    .ibuf_addr(ibuf_addr), .ibuf_rd(ibuf_rd), .ibuf_data(ibuf_data), .ibuf_valid(ibuf_valid),
    .reg_req(reg_req), .reg_we(reg_we), .reg_subsys(reg_subsys), .reg_offset(reg_offset),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack), .evt_in(evt_in),
    .irq(irq), .done(done), .err(err), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) begin
      ibuf_valid <= 1'b0;
      reg_ack <= 1'b0;
      ibuf_data <= '0;
      reg_rdata <= '0;
      last_sub <= '0;
    end else begin
      ibuf_valid <= ibuf_rd;
      ibuf_data <= imem[ibuf_addr[5:0]];
      if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        reg_rdata <= regs[reg_offset[4:1]];
        last_sub <= reg_subsys;
      end else reg_ack <= 1'b0;
    end
    if (poke_en) regs[poke_idx] <= poke_val;
    else if (rst_n && reg_req && !reg_ack && reg_we) regs[reg_offset[4:1]] <= reg_wdata;
  end

  always @(negedge clk) if (irq) irq_cnt++;

  function automatic logic [63:0] ins(input logic [7:0] op, input logic [7:0] sub,
                                      input logic [15:0] off, input logic [31:0] v);
    return {op, sub, off, v};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] v);
    @(negedge clk); poke_en = 1; poke_idx = 4'(idx); poke_val = v;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic kick(input int base);
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0; base_addr = AW'(base); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ev(input int n);
    @(negedge clk); evt_in[n] = 1'b1;
    @(negedge clk); evt_in[n] = 1'b0;
  endtask

  // masked, old, value, caller mask
  localparam logic [96:0] TBL [6] = '{
    {1'b0, 32'h12345678, 32'hCAFEF00D, 32'h0000FFFF},
    {1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF},
    {1'b1, 32'h00000000, 32'hFFFFFFFF, 32'hF0F0F0F0},
    {1'b1, 32'hAAAA5555, 32'h12345678, 32'h00FF00FF},
    {1'b1, 32'h13572468, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 32'h13572468, 32'h9ABCDEF0, 32'hFFFFFFFF}
  };

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = ins(8'h77, 8'h0, 16'h0, 32'h0);
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !irq, "R13 status after reset", {28'h0, busy, done, err, irq}, 32'h0);
    check(!ibuf_rd && !reg_req, "R13 no requests after reset", {30'h0, ibuf_rd, reg_req}, 32'h0);
    rst_n = 1;

    for (int r = 0; r < 6; r++) begin
      logic masked;
      logic [31:0] old, v, m, exp;
      int c0, idx;
      {masked, old, v, m} = TBL[r];
      idx = r + 1;
      exp = masked ? ((old & ~m) | (v & m)) : v;
      poke(idx, old);
      imem[0] = ins(8'h02, 8'h0, 16'h0, ~m);
      imem[1] = ins(8'h04, 8'(8'h20 + r), 16'(idx * 2 + (masked ? 1 : 0)), v);
      imem[2] = ins(8'h40, 8'h0, 16'h0, 32'h1);
      imem[3] = ins(8'h10, 8'h0, 16'h0, 32'h8);
      c0 = irq_cnt;
      kick(0);
      wait_end(200);
      check(regs[idx] == exp, masked ? "R3 masked write result" : "R2 full write ignores mask", regs[idx], exp);
      check(last_sub == 8'(8'h20 + r), "R1 subsystem field", 32'(last_sub), 32'(8'h20 + r));
      check(irq_cnt == c0 + 1, "R8 one irq pulse per EOC", irq_cnt, c0 + 1);
      check(done && !busy, "R9 pass jump sets done", {30'h0, done, busy}, 32'h2);
    end

    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    check(!done, "R9 done_clr clears done", 32'(done), 32'h0);

    // R4 poll blocks until register matches; EOC with bit0 clear gives no irq (R8)
    poke(3, 32'h0); poke(4, 32'h0);
    imem[0] = ins(8'h08, 8'h1, 16'h6, 32'h5);
    imem[1] = ins(8'h04, 8'h1, 16'h8, 32'hAA);
    imem[2] = ins(8'h40, 8'h0, 16'h0, 32'h0);
    imem[3] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    begin
      int c0;
      c0 = irq_cnt;
      kick(0);
      idle(40);
      check(busy && !done && regs[4] == 32'h0, "R4 poll stalls later instructions", regs[4], 32'h0);
      poke(3, 32'h5);
      wait_end(200);
      check(done && regs[4] == 32'hAA, "R4 poll releases on match", regs[4], 32'hAA);
      check(irq_cnt == c0, "R8 EOC without bit0 gives no irq", irq_cnt, c0);
    end

    // R4 masked poll: caller mask 0x0F, register 0xF5, value 0x05
    poke(3, 32'hF5);
    imem[0] = ins(8'h02, 8'h1, 16'h0, ~32'h0000000F);
    imem[1] = ins(8'h08, 8'h1, 16'h7, 32'h5);
    imem[2] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    kick(0); wait_end(100);
    check(done && !err, "R4 masked poll matches under mask", 32'(done), 32'h1);

    // R12 start while busy ignored
    poke(3, 32'h0); poke(5, 32'h0);
    imem[0] = ins(8'h08, 8'h1, 16'h6, 32'h9);
    imem[1] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    imem[20] = ins(8'h04, 8'h1, 16'hA, 32'h55);
    imem[21] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    kick(0); idle(10);
    @(negedge clk); base_addr = 20; start = 1; @(negedge clk); start = 0;
    idle(10);
    poke(3, 32'h9);
    wait_end(200); idle(5);
    check(done && regs[5] == 32'h0, "R12 start during busy ignored", regs[5], 32'h0);

    // R5 wait and clear
    imem[0] = ins(8'h20, 8'h0, 16'd3, 32'h80008001);
    imem[1] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    kick(0); idle(40);
    check(busy && !done, "R5 wait blocks on clear flag", 32'(done), 32'h0);
    pulse_ev(3); wait_end(100);
    check(done, "R5 event releases wait", 32'(done), 32'h1);

    // R5 consumption clears flag: second wait blocks
    pulse_ev(5);
    imem[0] = ins(8'h20, 8'h0, 16'd5, 32'h80008001);
    imem[1] = ins(8'h20, 8'h0, 16'd5, 32'h80008001);
    imem[2] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    kick(0); idle(40);
    check(busy && !done, "R5 flag cleared by consuming wait", 32'(done), 32'h0);
    pulse_ev(5); wait_end(100);
    check(done, "R5 second wait released", 32'(done), 32'h1);

    // R7 pulse on the consuming edge wins over the clear
    pulse_ev(7);
    imem[0] = ins(8'h20, 8'h0, 16'd7, 32'h80008001);
    imem[1] = ins(8'h20, 8'h0, 16'd7, 32'h80008001);
    imem[2] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0; base_addr = 0; start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 10 && !ibuf_rd; i++) @(negedge clk);
    // fetch seen -> decode two edges later -> satisfied wait completes on the next edge
    idle(3);
    evt_in[7] = 1'b1; @(negedge clk); evt_in[7] = 1'b0;
    wait_end(100);
    check(done, "R7 coincident event survives clear", 32'(done), 32'h1);

    // R6 clear-only form does not wait
    pulse_ev(6);
    imem[0] = ins(8'h20, 8'h0, 16'd6, 32'h80000000);
    imem[1] = ins(8'h20, 8'h0, 16'd6, 32'h80008001);
    imem[2] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    kick(0); idle(40);
    check(busy && !done, "R6 clear-event drops flag", 32'(done), 32'h0);
    pulse_ev(6); wait_end(100);
    check(done, "R6 later wait released", 32'(done), 32'h1);

    // R10 relative jumps
    imem[40] = ins(8'h10, 8'h0, 16'h0, 32'd16);
    imem[41] = ins(8'h77, 8'h0, 16'h0, 32'h0);
    imem[42] = ins(8'h40, 8'h0, 16'h0, 32'h1);
    imem[43] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    begin
      int c0;
      c0 = irq_cnt;
      kick(40); wait_end(100);
      check(done && !err && irq_cnt == c0 + 1, "R10 forward jump skips word", irq_cnt, c0 + 1);
    end
    imem[44] = ins(8'h10, 8'h0, 16'h0, 32'd24);
    imem[45] = ins(8'h10, 8'h0, 16'h0, 32'h8);
    imem[46] = ins(8'h77, 8'h0, 16'h0, 32'h0);
    imem[47] = ins(8'h10, 8'h0, 16'h0, 32'hFFFFFFF0);
    kick(44); wait_end(100);
    check(done && !err, "R10 backward jump", {30'h0, done, err}, 32'h2);

    // R11 faults
    imem[50] = ins(8'h77, 8'h0, 16'h0, 32'h0);
    kick(50); wait_end(100); idle(1);
    check(err && !done && !busy, "R11 unknown opcode halts", {29'h0, err, done, busy}, 32'h4);
    imem[52] = ins(8'h20, 8'h0, 16'd40, 32'h80008001);
    kick(52); wait_end(100); idle(1);
    check(err && !busy, "R11 event number out of range", 32'(err), 32'h1);
    kick(40); wait_end(100);
    check(!err && done, "R11 start clears err", 32'(err), 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule